// File: doc/BRIEF.md
# Three-Level Page Table Walker

This block resolves a miss in an address translation buffer. When the buffer cannot translate a virtual address, it passes the address and the access type to the walker. The walker then reads one entry at each of three table levels in memory. The walk starts from the root table of the current process, which the per-process base register names. The walker issues 8-byte reads over a simple valid/ready memory port and waits for a single response to each read.

A walk that finds a valid entry at every level returns the final entry's physical page number and protection bits so that the buffer can be filled. A walk that meets an invalid entry at any level stops at once and reports a page fault, together with the level at which it stopped. A virtual address whose upper bits are not a sign extension of bit 42 faults before any read is made. Only one walk is in flight at a time. The request side is refused while a walk runs. Every walk ends in a one-cycle result pulse.

Top module: `pt_walker`

## Requirements
- R1: After reset, `miss_ready` is 1 and `mem_req_valid`, `fill_valid` and `fault_valid` are 0.
- R2: The virtual page number splits into a first-level index `miss_va[42:33]`, a second-level index `miss_va[32:23]` and a third-level index `miss_va[22:13]`. Each entry address is `{table_ppn, index, 3'b000}`, which is 41 bits wide. The first table is `ptbr`, and each later table is the page number of the entry read at the level before it.
- R3: A table entry has its valid bit at bit 0, its protection bits at [4:1] and its 28-bit page number at [59:32]. When the third-level entry is valid, `fill_valid` pulses with that entry's page number and protection bits. `out_vpn` carries `miss_va[42:13]` and `out_wr` carries the access type of the request.
- R4: A walk that succeeds makes exactly three memory reads: first level, then second, then third. Each level makes one read.
- R5: An entry with bit 0 clear at level n (1 to 3) ends the walk with a `fault_valid` pulse and `fault_level` = n. Exactly n reads have been made, and no read follows.
- R6: If `miss_va[VA_W-1:42]` is not all zeros or all ones, the walk ends with `fault_valid` and `fault_level` = 0 in the cycle after acceptance, and no read is made. An address whose upper bits are all ones walks normally.
- R7: `miss_ready` is 0 from the cycle after a request is accepted until the result pulse has ended. Any `miss_valid` in that time is ignored.
- R8: `fill_valid` and `fault_valid` are never high together. Each lasts exactly one cycle, and `miss_ready` returns in the next cycle.
- R9: `ptbr` is sampled when the request is accepted. Changing it during a walk does not change that walk's addresses or its result.
- R10: Once `mem_req_valid` rises, it stays high with a stable `mem_req_addr` until `mem_req_ready` is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ptbr | input | 28 | Page number of the current process's root table |
| miss_valid | input | 1 | Miss request present |
| miss_ready | output | 1 | Walker idle, request accepted when valid |
| miss_va | input | 48 | Virtual address that missed |
| miss_wr | input | 1 | Access type of the miss (1 = write) |
| mem_req_valid | output | 1 | Memory read request |
| mem_req_ready | input | 1 | Memory accepts the read |
| mem_req_addr | output | 41 | Physical byte address of the 8-byte entry |
| mem_rsp_valid | input | 1 | Read data returned |
| mem_rsp_data | input | 64 | Entry read from memory |
| fill_valid | output | 1 | One-cycle pulse, translation complete |
| fill_ppn | output | 28 | Translated physical page number |
| fill_prot | output | 4 | Protection enables of the final entry |
| fault_valid | output | 1 | One-cycle pulse, page fault |
| fault_level | output | 2 | 0 = bad address form, 1 to 3 = level of the invalid entry |
| out_vpn | output | 30 | Virtual page number of the finished walk |
| out_wr | output | 1 | Access type of the finished walk |

## Verification
A wrong level or a stale table base shows up on `mem_req_addr` at the next read request, so it is visible within one handshake of the fault. A lost or extra state transition shows up as a read count other than the level reached when the result pulse appears. It can also show up as `miss_ready` coming back early in the middle of a walk. A corrupted result register reaches `fill_ppn`, `fill_prot` or `out_vpn` in the single pulse cycle that ends the walk.

// File: rtl/pt_walker.sv
module pt_walker #(
  parameter int VA_W    = 48,
  parameter int PPN_W   = 28,
  parameter int IDX_W   = 10,
  parameter int OFF_W   = 13,
  parameter int PROT_W  = 4,
  parameter int PTE_W   = 64,
  parameter int PPN_LSB = 32
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [PPN_W-1:0]       ptbr,
  input  logic                   miss_valid,
  output logic                   miss_ready,
  input  logic [VA_W-1:0]        miss_va,
  input  logic                   miss_wr,
  output logic                   mem_req_valid,
  input  logic                   mem_req_ready,
  output logic [PPN_W+OFF_W-1:0] mem_req_addr,
  input  logic                   mem_rsp_valid,
  input  logic [PTE_W-1:0]       mem_rsp_data,
  output logic                   fill_valid,
  output logic [PPN_W-1:0]       fill_ppn,
  output logic [PROT_W-1:0]      fill_prot,
  output logic                   fault_valid,
  output logic [1:0]             fault_level,
  output logic [3*IDX_W-1:0]     out_vpn,
  output logic                   out_wr
);
  localparam int VPN_W = 3 * IDX_W;
  localparam int TOP   = OFF_W + VPN_W;
  localparam int HI_W  = VA_W - TOP + 1;
  localparam int ESH   = $clog2(PTE_W / 8);

  typedef enum logic [3:0] {
    S_IDLE, S_L1_REQ, S_L1_WAIT, S_L2_REQ, S_L2_WAIT,
    S_L3_REQ, S_L3_WAIT, S_DONE, S_FAULT
  } st_t;

  st_t               st;
  logic [VPN_W-1:0]  vpn_q;
  logic [PPN_W-1:0]  base_q;
  logic [PROT_W-1:0] prot_q;
  logic [1:0]        flvl_q;
  logic              wr_q;
  logic [IDX_W-1:0]  idx;
  logic [1:0]        wait_lvl;

  wire [HI_W-1:0]   va_hi     = miss_va[VA_W-1:TOP-1];
  wire              canon     = (&va_hi) | ~(|va_hi);
  wire              pte_v     = mem_rsp_data[0];
  wire [PROT_W-1:0] pte_prot  = mem_rsp_data[PROT_W:1];
  wire [PPN_W-1:0]  pte_ppn   = mem_rsp_data[PPN_LSB +: PPN_W];
  wire              in_wait   = (st == S_L1_WAIT) || (st == S_L2_WAIT) || (st == S_L3_WAIT);
  wire              unused_ok = ^{miss_va[OFF_W-1:0], mem_rsp_data[PPN_LSB-1:PROT_W+1],
                                  mem_rsp_data[PTE_W-1:PPN_LSB+PPN_W]};

  always_comb begin
    case (st)
      S_L1_REQ: idx = vpn_q[VPN_W-1 -: IDX_W];
      S_L2_REQ: idx = vpn_q[2*IDX_W-1 -: IDX_W];
      default:  idx = vpn_q[IDX_W-1:0];
    endcase
  end

  always_comb begin
    case (st)
      S_L1_WAIT: wait_lvl = 2'd1;
      S_L2_WAIT: wait_lvl = 2'd2;
      default:   wait_lvl = 2'd3;
    endcase
  end

  assign miss_ready    = (st == S_IDLE);
  assign mem_req_valid = (st == S_L1_REQ) || (st == S_L2_REQ) || (st == S_L3_REQ);
  assign mem_req_addr  = {base_q, OFF_W'({idx, {ESH{1'b0}}})};
  assign fill_valid    = (st == S_DONE);
  assign fault_valid   = (st == S_FAULT);
  assign fill_ppn      = base_q;
  assign fill_prot     = prot_q;
  assign fault_level   = flvl_q;
  assign out_vpn       = vpn_q;
  assign out_wr        = wr_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      vpn_q  <= '0;
      base_q <= '0;
      prot_q <= '0;
      flvl_q <= '0;
      wr_q   <= 1'b0;
    end else begin
      case (st)
        S_IDLE: if (miss_valid) begin
          vpn_q  <= miss_va[TOP-1:OFF_W];
          wr_q   <= miss_wr;
          base_q <= ptbr;
          if (canon) st <= S_L1_REQ;
          else begin
            flvl_q <= 2'd0;
            st     <= S_FAULT;
          end
        end
        S_L1_REQ: if (mem_req_ready) st <= S_L1_WAIT;
        S_L2_REQ: if (mem_req_ready) st <= S_L2_WAIT;
        S_L3_REQ: if (mem_req_ready) st <= S_L3_WAIT;
        S_DONE, S_FAULT: st <= S_IDLE;
        default: if (in_wait && mem_rsp_valid) begin
          if (!pte_v) begin
            flvl_q <= wait_lvl;
            st     <= S_FAULT;
          end else begin
            base_q <= pte_ppn;
            case (st)
              S_L1_WAIT: st <= S_L2_REQ;
              S_L2_WAIT: st <= S_L3_REQ;
              default: begin
                prot_q <= pte_prot;
                st     <= S_DONE;
              end
            endcase
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/pt_walker_chk.sv
module pt_walker_chk #(
  parameter int VA_W  = 48,
  parameter int PPN_W = 28,
  parameter int OFF_W = 13
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   miss_valid,
  input logic                   miss_ready,
  input logic [VA_W-1:0]        miss_va,
  input logic                   mem_req_valid,
  input logic                   mem_req_ready,
  input logic [PPN_W+OFF_W-1:0] mem_req_addr,
  input logic                   fill_valid,
  input logic                   fault_valid,
  input logic [1:0]             fault_level
);
  wire [VA_W-43:0] hi    = miss_va[VA_W-1:42];
  wire             canon = (hi == '0) || (hi == '1);
  logic [2:0]      nrd;

  always_ff @(posedge clk) begin
    if (!rst_n) nrd <= '0;
    else if (miss_valid && miss_ready) nrd <= '0;
    else if (mem_req_valid && mem_req_ready) nrd <= nrd + 3'd1;
  end

  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    miss_ready |-> !mem_req_valid);
  p_three_reads_r4: assert property (@(posedge clk) disable iff (!rst_n)
    fill_valid |-> nrd == 3'd3);
  p_fault_reads_r5: assert property (@(posedge clk) disable iff (!rst_n)
    fault_valid |-> nrd == {1'b0, fault_level});
  p_noncanon_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (miss_valid && miss_ready && !canon) |=> (fault_valid && fault_level == 2'd0));
  p_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (miss_valid && miss_ready) |=> !miss_ready);
  p_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(fill_valid && fault_valid));
  p_fill_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    fill_valid |=> (!fill_valid && miss_ready));
  p_fault_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    fault_valid |=> (!fault_valid && miss_ready));
  p_req_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));
endmodule

bind pt_walker pt_walker_chk #(.VA_W(VA_W), .PPN_W(PPN_W), .OFF_W(OFF_W)) u_chk (.*);

// File: tb/tb_pt_walker.sv
`timescale 1ns/1ps
module tb_pt_walker;
  logic        clk = 0, rst_n = 0;
  logic [27:0] ptbr = '0;
  logic        miss_valid = 0, miss_wr = 0;
  logic [47:0] miss_va = '0;
  logic        mem_req_ready = 0, mem_rsp_valid = 0;
  logic [63:0] mem_rsp_data = '0;
  logic        miss_ready, mem_req_valid, fill_valid, fault_valid, out_wr;
  logic [40:0] mem_req_addr;
  logic [27:0] fill_ppn;
  logic [3:0]  fill_prot;
  logic [1:0]  fault_level;
  logic [29:0] out_vpn;

  pt_walker dut (.*);

  always #2 clk = ~clk;

  int nchk = 0, nfail = 0;
  int req_dly = 0, rsp_dly = 0, reads = 0;
  logic [40:0] alog [4];
  logic [40:0] mk_a [8];
  logic [63:0] mk_d [8];
  int mk_n = 0;
  logic [40:0] ea [4];

  bit g_fill, g_fault, g_wr;
  logic [1:0] g_lvl;
  logic [27:0] g_ppn;
  logic [3:0] g_prot;
  logic [29:0] g_vpn;
  int busy_bad;

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] pte(input logic [27:0] p, input logic [3:0] pr, input bit v);
    logic [63:0] e = 64'h0;
    e[0] = v; e[4:1] = pr; e[59:32] = p; e[23:8] = 16'hBEEF;
    return e;
  endfunction

  function automatic logic [63:0] lookup(input logic [40:0] a);
    for (int i = 0; i < mk_n; i++) if (mk_a[i] == a) return mk_d[i];
    return 64'h0;
  endfunction

  function automatic logic [47:0] mkva(input logic [9:0] i1, i2, i3, input logic [12:0] off);
    return {{5{i1[9]}}, i1, i2, i3, off};
  endfunction

  initial forever begin
    @(negedge clk);
    if (mem_req_valid) begin
      repeat (req_dly) @(negedge clk);
      mem_req_ready = 1;
      if (reads < 4) alog[reads] = mem_req_addr;
      @(negedge clk);
      mem_req_ready = 0;
      reads++;
      repeat (rsp_dly) @(negedge clk);
      mem_rsp_valid = 1;
      mem_rsp_data = lookup(alog[(reads-1) % 4]);
      @(negedge clk);
      mem_rsp_valid = 0;
    end
  end

  task automatic setup(input logic [27:0] root, input logic [47:0] va, input int drop,
                       input logic [27:0] pf, input logic [3:0] prf);
    logic [27:0] p2 = 28'h0000456, p3 = 28'h0C0FFEE;
    mk_n = 0;
    ea[1] = {root, va[42:33], 3'b000};
    ea[2] = {p2, va[32:23], 3'b000};
    ea[3] = {p3, va[22:13], 3'b000};
    mk_a[0] = ea[1]; mk_d[0] = pte(p2, 4'hF, drop != 1);
    mk_a[1] = ea[2]; mk_d[1] = pte(p3, 4'hF, drop != 2);
    mk_a[2] = ea[3]; mk_d[2] = pte(pf, prf, drop != 3);
    mk_n = 3;
  endtask

  task automatic run_walk(input logic [47:0] va, input bit wr, input logic [27:0] root,
                          input logic [27:0] mid_root, input bit poke);
    int n = 0;
    reads = 0; busy_bad = 0;
    @(negedge clk);
    ptbr = root; miss_va = va; miss_wr = wr; miss_valid = 1;
    @(negedge clk);
    ptbr = mid_root;
    if (poke) begin miss_va = ~va; miss_wr = ~wr; end
    else miss_valid = 0;
    while (!(fill_valid || fault_valid) && n < 300) begin
      if (miss_ready) busy_bad++;
      if (poke && n == 3) miss_valid = 0;
      @(negedge clk);
      n++;
    end
    miss_valid = 0;
    if (miss_ready) busy_bad++;
    g_fill = fill_valid; g_fault = fault_valid; g_lvl = fault_level;
    g_ppn = fill_ppn; g_prot = fill_prot; g_vpn = out_vpn; g_wr = out_wr;
    @(negedge clk);
    chk("R8 pulse ends", {fill_valid, fault_valid}, 2'b00);
    chk("R8 ready returns", miss_ready, 1'b1);
  endtask

  task automatic t_reset();
    chk("R1 ready", miss_ready, 1'b1);
    chk("R1 no req", mem_req_valid, 1'b0);
    chk("R1 no pulse", {fill_valid, fault_valid}, 2'b00);
  endtask

  task automatic expect_fill(input string tag, input logic [47:0] va, input bit wr,
                             input logic [27:0] pf, input logic [3:0] prf);
    chk({tag, " R3 fill"}, {g_fill, g_fault}, 2'b10);
    chk({tag, " R4 reads"}, reads, 3);
    for (int i = 1; i <= 3; i++) chk({tag, " R2 addr"}, alog[i-1], ea[i]);
    chk({tag, " R3 ppn"}, g_ppn, pf);
    chk({tag, " R3 prot"}, g_prot, prf);
    chk({tag, " R3 vpn"}, g_vpn, va[42:13]);
    chk({tag, " R3 wr"}, g_wr, wr);
    chk({tag, " R7 busy"}, busy_bad, 0);
  endtask

  task automatic t_full_walk();
    logic [47:0] va = mkva(10'h003, 10'h155, 10'h3FF, 13'h1ABC);
    setup(28'h0000123, va, 0, 28'hABCDE01, 4'b1010);
    run_walk(va, 1, 28'h0000123, 28'h0000123, 0);
    expect_fill("basic", va, 1, 28'hABCDE01, 4'b1010);
  endtask

  task automatic t_negative_va();
    logic [47:0] va = mkva(10'h2A1, 10'h000, 10'h201, 13'h0);
    setup(28'h7654321, va, 0, 28'h0000001, 4'b0101);
    run_walk(va, 0, 28'h7654321, 28'h7654321, 0);
    expect_fill("R6 upper ones", va, 0, 28'h0000001, 4'b0101);
  endtask

  task automatic t_backpressure();
    logic [47:0] va = mkva(10'h1FF, 10'h2AA, 10'h011, 13'h0FF);
    setup(28'h0000ABC, va, 0, 28'h1234567, 4'b0011);
    req_dly = 3; rsp_dly = 2;
    run_walk(va, 1, 28'h0000ABC, 28'h0000ABC, 0);
    expect_fill("R10 stalled", va, 1, 28'h1234567, 4'b0011);
    req_dly = 0; rsp_dly = 0;
  endtask

  task automatic t_fault(input int lvl);
    logic [47:0] va = mkva(10'h0F0, 10'h10F, 10'h0AA, 13'h5);
    setup(28'h0000999, va, lvl, 28'h0000777, 4'hF);
    run_walk(va, 0, 28'h0000999, 28'h0000999, 0);
    chk("R5 fault", {g_fill, g_fault}, 2'b01);
    chk("R5 level", g_lvl, lvl);
    chk("R5 reads", reads, lvl);
    chk("R5 last addr", alog[lvl-1], ea[lvl]);
    chk("R5 vpn", g_vpn, va[42:13]);
  endtask

  task automatic t_noncanon(input logic [47:0] va);
    setup(28'h0000123, va, 0, 28'h0000111, 4'h1);
    run_walk(va, 1, 28'h0000123, 28'h0000123, 0);
    chk("R6 fault", {g_fill, g_fault}, 2'b01);
    chk("R6 level", g_lvl, 2'd0);
    chk("R6 no reads", reads, 0);
  endtask

  task automatic t_ptbr_switch();
    logic [47:0] va = mkva(10'h045, 10'h067, 10'h089, 13'h10);
    setup(28'h0001000, va, 0, 28'h0BADCAF, 4'b1100);
    run_walk(va, 0, 28'h0001000, 28'h0002000, 0);
    expect_fill("R9 root switch", va, 0, 28'h0BADCAF, 4'b1100);
  endtask

  task automatic t_busy_ignore();
    logic [47:0] va = mkva(10'h0AB, 10'h0CD, 10'h0EF, 13'h3);
    setup(28'h0000042, va, 0, 28'h0000F00, 4'b0110);
    run_walk(va, 1, 28'h0000042, 28'h0000042, 1);
    expect_fill("R7 ignore miss", va, 1, 28'h0000F00, 4'b0110);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    t_reset();
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_full_walk();
    t_negative_va();
    t_backpressure();
    t_fault(1);
    t_fault(2);
    t_fault(3);
    t_noncanon(48'h1000_0000_0000);
    t_noncanon(48'hF7FF_FFFF_FFFF);
    t_ptbr_switch();
    t_busy_ignore();
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end
endmodule